// File: doc/BRIEF.md
# Buffered Serial Transmitter with Queue Status Flags

This block takes bytes from a host, queues them in a 64-entry first-in first-out store and sends them one after another on a single serial line. Each byte becomes a frame with one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high between frames. Bit timing comes from an oversampling tick that the baud generator outside the block supplies. A run-time select sets each bit to 16 ticks or to 8 ticks.

The host sees two status flags. `thr_empty` says the queue holds nothing. `tx_empty` says that the queue and the shift stage are both idle. An interrupt request warns the host that the queue is running low. It goes pending when a transmit load makes the fill level fall below a programmed threshold, and again when the queue drains to zero. The next accepted write clears it. An enable input gates it to the pin. A write that arrives while the queue is full is thrown away and reported with a one-cycle overflow pulse.

A small state machine drives the shift stage. Its states are IDLE (line high, waiting for data), START (start bit), DATA (eight data bits) and STOP (stop bit). The transitions are:
- IDLE→START when the queue has data.
- START→DATA at the end of the start bit.
- DATA→STOP after the last data bit.
- STOP→START at the end of the stop bit when the queue still has data.
- STOP→IDLE at the end of the stop bit when the queue is empty.

Top module: `uart_tx_fifo`

## Requirements
- R1: Each frame is one start bit at 0, then 8 data bits with bit 0 sent first, then one stop bit at 1. `txd` is 1 whenever no frame is in progress.
- R2: A bit lasts 16 `tick` pulses when `sel_8x`=0 and 8 pulses when `sel_8x`=1. With `tick` held at 1, a frame loaded at a clock edge ends exactly 10×(bit length) edges later.
- R3: Bit timing advances only on cycles where `tick` is 1. With `tick` at 0, a started frame holds its current bit.
- R4: `thr_empty` is 1 exactly when the queue holds no byte. A byte moves into the shift stage one edge after it is written into an empty queue while the machine is in IDLE.
- R5: `tx_empty` is 1 only when the queue is empty and the state machine is in IDLE.
- R6: When the queue is not empty at the end of a stop bit, the next byte's start bit begins at that same edge, with no idle time between the frames.
- R7: The queue holds 64 bytes. A write while it is full is dropped, and `overflow` is 1 for the one cycle after that write edge.
- R8: A load that takes the fill level from the value of `trig_lvl` to one below it, with no write in the same cycle, makes the interrupt pending. An accepted write clears the pending interrupt.
- R9: A load that leaves the queue empty, with no write in the same cycle, makes the interrupt pending.
- R10: `irq` is 1 only while `irq_en` is 1 and the interrupt is pending. `irq_en` changes `irq` in the same cycle.
- R11: After reset `txd`=1, `thr_empty`=1, `tx_empty`=1, `irq`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick from the baud generator |
| sel_8x | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| trig_lvl | input | 7 | Low-water threshold for the interrupt |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial output |
| thr_empty | output | 1 | Queue holds no data |
| tx_empty | output | 1 | Queue and shift stage both idle |
| irq | output | 1 | Transmit-empty interrupt request |
| overflow | output | 1 | One-cycle pulse for a dropped write |

## Verification
A write is taken at the edge where `wr_en` is high. The load into the shift stage comes at the next edge, and bit k of that frame is on `txd` from edge 1+k×L to edge 1+(k+1)×L after the write, where L is the bit length. The bench counts clock edges from each write and samples `txd` at the falling edge in the middle of every bit. It reads `tx_empty` one cycle before and one cycle after the last edge of the frame, which pins the frame length exactly. The interrupt and the overflow pulse are registered, so the bench reads them at the falling edge just after the load or dropped-write edge that causes them. The bench reads `irq` again after `irq_en` changes, because the enable acts without delay.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              push_ok,
    output logic              drop_q
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign push_ok  = push && !full;
    assign pop_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= push && full;
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop)      count <= count + 1'b1;
            else if (pop && !push_ok) count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R7
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH))); // R7
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R6
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
    import uart_txq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel_8x,
    input  logic              have_data,
    input  logic [DATA_W-1:0] load_data,
    output logic              pop,
    output logic              txd,
    output logic              idle
);
    localparam int TC_W = $clog2(OVS);
    localparam int BI_W = $clog2(DATA_W);
    localparam logic [TC_W-1:0] LAST_FULL = TC_W'(OVS - 1);
    localparam logic [TC_W-1:0] LAST_HALF = TC_W'(OVS / 2 - 1);

    tx_state_t         state, nxt;
    logic [TC_W-1:0]   tcnt;
    logic [BI_W-1:0]   bidx;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = tick && (tcnt == (sel_8x ? LAST_HALF : LAST_FULL));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (have_data) nxt = ST_START;
            ST_START: if (bit_end) nxt = ST_DATA;
            ST_DATA:  if (bit_end && bidx == BI_W'(DATA_W - 1)) nxt = ST_STOP;
            ST_STOP:  if (bit_end) nxt = have_data ? ST_START : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else if (pop) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= load_data;
        end else if (state != ST_IDLE && tick) begin
            if (bit_end) begin
                tcnt <= '0;
                if (state == ST_DATA) begin
                    shreg <= shreg >> 1;
                    bidx  <= bidx + 1'b1;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    always_comb begin
        pop  = have_data && ((state == ST_IDLE) || (state == ST_STOP && bit_end));
        idle = (state == ST_IDLE);
        unique case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state != ST_IDLE) |=> $stable(txd)); // R3
    AST_START_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (state == ST_START)); // R6
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             pop,
    input  logic             push_ok,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic             irq_en,
    output logic             irq
);
    logic pending;
    logic drain_only;
    logic hit_trig, hit_empty;

    assign drain_only = pop && !push_ok;
    assign hit_trig   = drain_only && (count == trig_lvl);
    assign hit_empty  = drain_only && (count == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pending <= 1'b0;
        else if (push_ok)                pending <= 1'b0;
        else if (hit_trig || hit_empty)  pending <= 1'b1;
    end

    assign irq = pending && irq_en;

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> !irq); // R8
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int OVS    = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel_8x,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  trig_lvl,
    input  logic              irq_en,
    output logic              txd,
    output logic              thr_empty,
    output logic              tx_empty,
    output logic              irq,
    output logic              overflow
);
    logic [DATA_W-1:0] q_data;
    logic [CNT_W-1:0]  q_count;
    logic              q_full, q_empty, q_push_ok, q_pop, sh_idle;

    txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .push_data(wr_data),
        .pop(q_pop), .pop_data(q_data),
        .count(q_count), .full(q_full), .empty(q_empty),
        .push_ok(q_push_ok), .drop_q(overflow)
    );

    txq_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .tick(tick), .sel_8x(sel_8x),
        .have_data(!q_empty), .load_data(q_data),
        .pop(q_pop), .txd(txd), .idle(sh_idle)
    );

    txq_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .count(q_count), .pop(q_pop), .push_ok(q_push_ok),
        .trig_lvl(trig_lvl), .irq_en(irq_en), .irq(irq)
    );

    assign thr_empty = q_empty;
    assign tx_empty  = q_empty && sh_idle;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R1
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !tx_empty); // R5
endmodule

// File: tb/uart_tx_fifo_test.sv
module uart_tx_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       sel_8x = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [6:0] trig_lvl = 7'd0;
    logic       irq_en = 1'b0;
    logic       txd, thr_empty, tx_empty, irq, overflow;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_tx_fifo uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_8x(sel_8x),
        .wr_en(wr_en), .wr_data(wr_data), .trig_lvl(trig_lvl),
        .irq_en(irq_en), .txd(txd), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .irq(irq), .overflow(overflow)
    );

    // {sel_8x, byte}
    localparam logic [8:0] VEC [0:3] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h01}, {1'b1, 8'hFE}
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic run_frame(input logic s8, input logic [7:0] d);
        int bl;
        logic e;
        bl = s8 ? 8 : 16;
        @(negedge clk); sel_8x = s8; tick = 1'b1; wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        repeat (1 + bl / 2) @(posedge clk);
        @(negedge clk);
        chk("R4 queue empty once loaded", thr_empty, 1'b1);
        chk("R5 busy while shifting", tx_empty, 1'b0);
        for (int k = 0; k < 10; k++) begin
            if (k > 0) begin
                repeat (bl) @(posedge clk);
                @(negedge clk);
            end
            e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : d[k-1];
            chk("R1 R2 frame bit", txd, e);
        end
        repeat (bl / 2 - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 R5 frame not yet over", tx_empty, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R2 R5 frame over exactly", tx_empty, 1'b1);
        chk("R1 idle high", txd, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        irq_en = 1'b1;
        #1;
        chk("R11 txd", txd, 1'b1);
        chk("R11 thr_empty", thr_empty, 1'b1);
        chk("R11 tx_empty", tx_empty, 1'b1);
        chk("R11 irq", irq, 1'b0);
        chk("R11 overflow", overflow, 1'b0);
        rst_n = 1'b1;
        irq_en = 1'b0;

        for (int v = 0; v < 4; v++) run_frame(VEC[v][8], VEC[v][7:0]);

        // R6 back-to-back frames, 16x
        @(negedge clk); sel_8x = 1'b0; tick = 1'b1; wr_en = 1'b1; wr_data = 8'h0F;
        @(negedge clk); wr_data = 8'hF2;
        @(negedge clk); wr_en = 1'b0;
        repeat (168) @(posedge clk);
        @(negedge clk);
        chk("R6 second start bit without gap", txd, 1'b0);
        chk("R6 still busy", tx_empty, 1'b0);
        chk("R4 queue drained", thr_empty, 1'b1);
        repeat (16) @(posedge clk);
        @(negedge clk);
        chk("R6 second frame bit0", txd, 1'b0);
        repeat (16) @(posedge clk);
        @(negedge clk);
        chk("R6 second frame bit1", txd, 1'b1);
        for (int i = 0; i < 400 && !tx_empty; i++) @(negedge clk);
        chk("R5 idle after pair", tx_empty, 1'b1);

        // R9 R10 empty event
        @(negedge clk); trig_lvl = 7'd0; irq_en = 1'b1; sel_8x = 1'b1;
        wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 write clears pending", irq, 1'b0);
        @(negedge clk);
        chk("R9 empty raises irq", irq, 1'b1);
        irq_en = 1'b0; #1;
        chk("R10 gated off", irq, 1'b0);
        irq_en = 1'b1; #1;
        chk("R10 gated on", irq, 1'b1);
        for (int i = 0; i < 200 && !tx_empty; i++) @(negedge clk);

        // R8 threshold event, 8x, trig 4
        @(negedge clk); trig_lvl = 7'd4;
        for (int i = 0; i < 6; i++) begin
            wr_en = 1'b1; wr_data = 8'(8'h10 + i);
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R8 cleared by writes", irq, 1'b0);
        repeat (116) @(posedge clk);
        @(negedge clk);
        chk("R8 level 4 not below threshold", irq, 1'b0);
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk("R8 below threshold raises irq", irq, 1'b1);
        wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 accepted write clears", irq, 1'b0);
        irq_en = 1'b0;
        for (int i = 0; i < 1000 && !tx_empty; i++) @(negedge clk);
        chk("R10 pending hidden while disabled", irq, 1'b0);
        chk("R5 drained", tx_empty, 1'b1);

        // R3 R7 fill with tick low, then overflow
        @(negedge clk); tick = 1'b0; sel_8x = 1'b1;
        for (int i = 0; i < 66; i++) begin
            wr_en = 1'b1; wr_data = 8'(i);
            @(negedge clk);
            if (i == 64) chk("R7 no drop while space", overflow, 1'b0);
        end
        wr_en = 1'b0;
        chk("R7 drop pulse", overflow, 1'b1);
        chk("R4 queue holds data", thr_empty, 1'b0);
        @(negedge clk);
        chk("R7 pulse is one cycle", overflow, 1'b0);
        chk("R3 start bit held without tick", txd, 1'b0);
        tick = 1'b1;
        repeat (5199) @(posedge clk);
        @(negedge clk);
        chk("R7 65 frames not yet done", tx_empty, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R7 exactly 65 frames sent", tx_empty, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule